// File: doc/BRIEF.md
# Descriptor Ring Ownership Scanner

This block serves a network controller that keeps its receive and transmit buffers as two rings of 16 descriptors in shared memory. It walks a ring through a word read/write memory port, picks out the entries that software has marked ready, and hands each one off. A receive hand-off records the arrived length and a completed status in the descriptor. A transmit hand-off reads the stored buffer length, which is kept as a negative number, and asks the sender to emit that many bytes. When the sender confirms, the block marks the descriptor complete. Each hand-off produces a one-cycle event. The payload bytes do not pass through the block. The payload appears only as a length on a request/acknowledge pair.

A descriptor is 8 bytes long, and descriptor `k` sits at `base + 8*k`. Every descriptor access is a 16-bit word access on the memory port. The port uses a valid/ready handshake, and the block holds each request until the port takes it. A packet arrival is presented as a held request carrying its size. Any write to the controller's register port raises a transmit-scan request. The controller's stop flag blocks new scans.

Top module: `desc_ring_scanner`

## Requirements
- R1: After reset, `mem_valid`, `tx_send`, `rx_done`, `rx_event` and `tx_event` are low, and both ring indexes are 0.
- R2: Descriptor `k` of a ring starts at `base + 8*k`. Its status byte is bits [7:0] of the word at byte offset 2, and bits [15:8] of that word are kept unchanged. The buffer length is the word at offset 4 and the message length is the word at offset 6. A memory request holds its address and data until `mem_ready`.
- R3: A receive descriptor is accepted only when its status byte is exactly 0x80. Any other value, such as 0xC0 or 0x03, is skipped.
- R4: On a receive acceptance, the block writes `rx_size + 4` to the message length word. It then writes status 0x03 and pulses `rx_event` and `rx_done` together.
- R5: A receive scan ends at its first accepted descriptor. If no descriptor qualifies, the packet is dropped: `rx_done` pulses without `rx_event` and nothing is written.
- R6: A transmit descriptor is accepted only when its status byte is exactly 0x83. `tx_len` is the 16-bit two's complement negation of the stored length word. `tx_len` and `tx_send` are held until `tx_sent`.
- R7: After each send, the block writes status 0x03 and pulses `tx_event`. The same scan then goes on looking for further ready descriptors.
- R8: A scan starts at the ring's current index. It stops when the next position would be `(index - 1) mod 16`, so the descriptor just before the index is never examined.
- R9: Each acceptance advances that ring's index by exactly one, modulo 16. The advance is the same whatever position the accepted descriptor was found at.
- R10: While `stop` is high, no scan starts. A packet request is dropped (`rx_done` with no memory access), and a register write is discarded.
- R11: Every `reg_wr` pulse with `stop` low leads to a transmit scan. When a packet request and a pending transmit scan are both waiting, the receive scan runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop | input | 1 | Controller stop flag; blocks new scans |
| reg_wr | input | 1 | One-cycle pulse for each register-port write |
| rx_base | input | AW | Byte address of receive descriptor 0 |
| tx_base | input | AW | Byte address of transmit descriptor 0 |
| rx_req | input | 1 | Packet arrived; held until `rx_done` |
| rx_size | input | 16 | Packet size in bytes, held with `rx_req` |
| rx_done | output | 1 | Pulse: packet request finished (stored or dropped) |
| rx_event | output | 1 | Pulse: a receive descriptor was completed |
| tx_event | output | 1 | Pulse: a transmit descriptor was completed |
| tx_send | output | 1 | Send request, held until `tx_sent` |
| tx_len | output | 16 | Byte count for the send request |
| tx_sent | input | 1 | Sender accepts the send request |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |

## Verification
A packet arrival and a register write can land in the same cycle, and so compete for the single scanner. The bench raises `rx_req` and `reg_wr` on one edge, with a ready descriptor waiting in each ring. It then checks three things: exactly one receive and one transmit completion occur, the receive event comes in an earlier cycle than the transmit event, and the transmit request is not lost while the receive scan runs.

// File: rtl/desc_ring_scanner.sv
module desc_ring_scanner #(
  parameter int AW   = 16,
  parameter int IDXW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic          reg_wr,
  input  logic [AW-1:0] rx_base,
  input  logic [AW-1:0] tx_base,
  input  logic          rx_req,
  input  logic [15:0]   rx_size,
  output logic          rx_done,
  output logic          rx_event,
  output logic          tx_event,
  output logic          tx_send,
  output logic [15:0]   tx_len,
  input  logic          tx_sent,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata
);
  localparam logic [7:0] RX_READY = 8'h80;
  localparam logic [7:0] TX_READY = 8'h83;
  localparam logic [7:0] ST_DONE  = 8'h03;
  localparam logic [AW-1:0] OFF_STAT = AW'(2);
  localparam logic [AW-1:0] OFF_BLEN = AW'(4);
  localparam logic [AW-1:0] OFF_MLEN = AW'(6);

  typedef enum logic [2:0] {S_IDLE, S_RDST, S_ADV, S_WRLEN, S_RDLEN, S_SEND, S_WRST} st_t;

  st_t            st;
  logic           is_rx, tx_pend;
  logic [IDXW-1:0] pos, endp, rx_idx, tx_idx;
  logic [IDXW-1:0] pos_nx;
  logic [15:0]    len_r;
  logic [7:0]     stat_hi;
  logic [AW-1:0]  ring_base, desc_off, field_off;
  logic           hs;
  logic [7:0]     want;

  assign pos_nx    = pos + 1'b1;
  assign ring_base = is_rx ? rx_base : tx_base;
  assign desc_off  = AW'({pos, 3'b000});
  assign field_off = (st == S_WRLEN) ? OFF_MLEN : (st == S_RDLEN) ? OFF_BLEN : OFF_STAT;
  assign mem_addr  = ring_base + desc_off + field_off;
  assign mem_valid = (st == S_RDST) || (st == S_WRLEN) || (st == S_RDLEN) || (st == S_WRST);
  assign mem_write = (st == S_WRLEN) || (st == S_WRST);
  assign mem_wdata = (st == S_WRLEN) ? len_r : {stat_hi, ST_DONE};
  assign hs        = mem_valid && mem_ready;
  assign want      = is_rx ? RX_READY : TX_READY;
  assign tx_send   = (st == S_SEND);
  assign tx_len    = len_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_rx    <= 1'b0;
      tx_pend  <= 1'b0;
      pos      <= '0;
      endp     <= '0;
      rx_idx   <= '0;
      tx_idx   <= '0;
      len_r    <= '0;
      stat_hi  <= '0;
      rx_done  <= 1'b0;
      rx_event <= 1'b0;
      tx_event <= 1'b0;
    end else begin
      rx_done  <= 1'b0;
      rx_event <= 1'b0;
      tx_event <= 1'b0;
      tx_pend  <= (tx_pend | reg_wr) & ~stop;
      case (st)
        S_IDLE: begin
          if (rx_req && !rx_done) begin
            if (stop) begin
              rx_done <= 1'b1;
            end else begin
              is_rx <= 1'b1;
              pos   <= rx_idx;
              endp  <= rx_idx - 1'b1;
              len_r <= rx_size + 16'd4;
              st    <= S_RDST;
            end
          end else if (tx_pend && !stop) begin
            is_rx   <= 1'b0;
            pos     <= tx_idx;
            endp    <= tx_idx - 1'b1;
            tx_pend <= reg_wr;
            st      <= S_RDST;
          end
        end
        S_RDST: if (hs) begin
          stat_hi <= mem_rdata[15:8];
          if (mem_rdata[7:0] == want) st <= is_rx ? S_WRLEN : S_RDLEN;
          else                        st <= S_ADV;
        end
        S_ADV: begin
          if (pos_nx == endp) begin
            st <= S_IDLE;
            if (is_rx) rx_done <= 1'b1;
          end else begin
            pos <= pos_nx;
            st  <= S_RDST;
          end
        end
        S_WRLEN: if (hs) st <= S_WRST;
        S_RDLEN: if (hs) begin
          len_r <= ~mem_rdata + 16'd1;
          st    <= S_SEND;
        end
        S_SEND: if (tx_sent) st <= S_WRST;
        S_WRST: if (hs) begin
          if (is_rx) begin
            rx_idx   <= rx_idx + 1'b1;
            rx_event <= 1'b1;
            rx_done  <= 1'b1;
            st       <= S_IDLE;
          end else begin
            tx_idx   <= tx_idx + 1'b1;
            tx_event <= 1'b1;
            st       <= S_ADV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));

  assert_rx_event_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> rx_done);

  assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_event, tx_event}));

  assert_send_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_send && !tx_sent) |=> (tx_send && $stable(tx_len)));

  assert_rx_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> (rx_idx == $past(rx_idx) + 1'b1));

  assert_tx_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event |-> (tx_idx == $past(tx_idx) + 1'b1));

  assert_stop_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && st == S_IDLE) |=> (st == S_IDLE));
endmodule

// File: tb/tb_desc_ring_scanner.sv
module tb_desc_ring_scanner;
  localparam int AW = 16;
  localparam logic [15:0] RXB = 16'h0100;
  localparam logic [15:0] TXB = 16'h0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b0, reg_wr = 1'b0, rx_req = 1'b0, tx_sent = 1'b0, mem_ready = 1'b0;
  logic [15:0] rx_size = '0, mem_rdata = '0, tx_len, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic rx_done, rx_event, tx_event, tx_send, mem_valid, mem_write;

  always #2 clk = ~clk;

  desc_ring_scanner #(.AW(AW), .IDXW(4)) dut (
    .clk(clk), .rst_n(rst_n), .stop(stop), .reg_wr(reg_wr),
    .rx_base(RXB), .tx_base(TXB), .rx_req(rx_req), .rx_size(rx_size),
    .rx_done(rx_done), .rx_event(rx_event), .tx_event(tx_event),
    .tx_send(tx_send), .tx_len(tx_len), .tx_sent(tx_sent),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic [15:0] mem [0:511];
  int checks = 0, errors = 0;
  int acc_cnt = 0, wr_cnt = 0, rx_cnt = 0, tx_cnt = 0, sent_n = 0, cyc = 0;
  int rx_cyc = 0, tx_cyc = 0;
  logic [15:0] sent_log [0:31];

  function automatic int widx(logic [15:0] base, int e, int off);
    return ((int'(base) + e * 8 + off) >> 1) & 511;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rx_event) begin rx_cnt++; rx_cyc = cyc; end
    if (tx_event) begin tx_cnt++; tx_cyc = cyc; end
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      mem_ready = 1'b1;
      acc_cnt++;
      if (mem_write) begin mem[(int'(mem_addr) >> 1) & 511] = mem_wdata; wr_cnt++; end
      else mem_rdata = mem[(int'(mem_addr) >> 1) & 511];
    end
    if (tx_sent) tx_sent = 1'b0;
    else if (tx_send) begin
      tx_sent = 1'b1;
      if (sent_n < 32) sent_log[sent_n] = tx_len;
      sent_n++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    summary();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic packet(int size, output bit done_seen);
    rx_req = 1'b1; rx_size = 16'(size);
    done_seen = 1'b0;
    for (int k = 0; k < 2000 && !done_seen; k++) begin
      @(negedge clk);
      if (rx_done) done_seen = 1'b1;
    end
    rx_req = 1'b0;
    idle(4);
  endtask

  task automatic poke_wr();
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(200);
  endtask

  task automatic clear_rx();
    for (int e = 0; e < 16; e++) mem[widx(RXB, e, 2)] = 16'h0000;
  endtask

  task automatic t_reset();
    chk("R1 mem_valid", int'(mem_valid), 0);
    chk("R1 tx_send", int'(tx_send), 0);
    chk("R1 rx_done", int'(rx_done), 0);
    chk("R1 events", int'({rx_event, tx_event}), 0);
  endtask

  task automatic t_rx_basic();
    bit d;
    mem[widx(RXB, 0, 2)] = 16'h5A80;
    packet(60, d);
    chk("R4 done", int'(d), 1);
    chk("R4 msg len", int'(mem[widx(RXB, 0, 6)]), 64);
    chk("R2 R4 status word", int'(mem[widx(RXB, 0, 2)]), 16'h5A03);
    chk("R4 rx_event", rx_cnt, 1);
  endtask

  task automatic t_rx_exact();
    bit d;
    clear_rx();
    mem[widx(RXB, 1, 2)] = 16'h00C0;
    mem[widx(RXB, 2, 2)] = 16'h0080;
    packet(1500, d);
    chk("R3 non-exact skipped", int'(mem[widx(RXB, 1, 2)]), 16'h00C0);
    chk("R3 exact taken", int'(mem[widx(RXB, 2, 2)]), 16'h0003);
    chk("R4 msg len 1504", int'(mem[widx(RXB, 2, 6)]), 1504);
  endtask

  task automatic t_rx_index();
    bit d;
    clear_rx();
    mem[widx(RXB, 2, 2)] = 16'h0080;
    mem[widx(RXB, 5, 2)] = 16'h0080;
    packet(100, d);
    chk("R9 index stepped by one", int'(mem[widx(RXB, 2, 2)]), 16'h0003);
    chk("R5 stop after first", int'(mem[widx(RXB, 5, 2)]), 16'h0080);
    chk("R9 rx count", rx_cnt, 3);
  endtask

  task automatic t_rx_drop();
    bit d;
    int w0, e0;
    clear_rx();
    w0 = wr_cnt; e0 = rx_cnt;
    packet(80, d);
    chk("R5 drop done", int'(d), 1);
    chk("R5 drop no write", wr_cnt - w0, 0);
    chk("R5 drop no event", rx_cnt - e0, 0);
  endtask

  task automatic t_rx_bound();
    bit d;
    int e0;
    clear_rx();
    mem[widx(RXB, 2, 2)] = 16'h0080;
    e0 = rx_cnt;
    packet(80, d);
    chk("R8 entry before index unseen", int'(mem[widx(RXB, 2, 2)]), 16'h0080);
    chk("R8 no event", rx_cnt - e0, 0);
    clear_rx();
  endtask

  task automatic t_tx_multi();
    mem[widx(TXB, 0, 2)] = 16'h0083; mem[widx(TXB, 0, 4)] = 16'hFF9C;
    mem[widx(TXB, 1, 2)] = 16'h0082; mem[widx(TXB, 1, 4)] = 16'hFFF0;
    mem[widx(TXB, 2, 2)] = 16'h7783; mem[widx(TXB, 2, 4)] = 16'hFFC0;
    poke_wr();
    chk("R11 R7 sends", sent_n, 2);
    chk("R6 first len", int'(sent_log[0]), 100);
    chk("R6 second len", int'(sent_log[1]), 64);
    chk("R7 status 0", int'(mem[widx(TXB, 0, 2)]), 16'h0003);
    chk("R7 status 2 keeps high byte", int'(mem[widx(TXB, 2, 2)]), 16'h7703);
    chk("R6 0x82 skipped", int'(mem[widx(TXB, 1, 2)]), 16'h0082);
    chk("R7 tx events", tx_cnt, 2);
  endtask

  task automatic t_tx_bound();
    mem[widx(TXB, 1, 2)] = 16'h0083;
    poke_wr();
    chk("R8 R9 entry before index unseen", sent_n, 2);
    mem[widx(TXB, 1, 2)] = 16'h0000;
  endtask

  task automatic t_stop();
    bit d;
    int a0;
    stop = 1'b1;
    mem[widx(TXB, 4, 2)] = 16'h0083; mem[widx(TXB, 4, 4)] = 16'h8000;
    mem[widx(RXB, 3, 2)] = 16'h0080;
    idle(2);
    a0 = acc_cnt;
    packet(50, d);
    chk("R10 rx dropped done", int'(d), 1);
    chk("R10 no memory access", acc_cnt - a0, 0);
    chk("R10 rx entry untouched", int'(mem[widx(RXB, 3, 2)]), 16'h0080);
    poke_wr();
    chk("R10 no send while stopped", sent_n, 2);
    stop = 1'b0;
    idle(200);
    chk("R10 write discarded", sent_n, 2);
    poke_wr();
    chk("R11 send after stop", sent_n, 3);
    chk("R6 len 0x8000", int'(sent_log[2]), 16'h8000);
  endtask

  task automatic t_both();
    bit d;
    int r0, t0;
    mem[widx(TXB, 3, 2)] = 16'h0083; mem[widx(TXB, 3, 4)] = 16'hFFF0;
    r0 = rx_cnt; t0 = tx_cnt;
    rx_req = 1'b1; rx_size = 16'd40; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    d = 1'b0;
    for (int k = 0; k < 2000 && !d; k++) begin
      if (rx_done) d = 1'b1;
      else @(negedge clk);
    end
    rx_req = 1'b0;
    idle(200);
    chk("R11 rx completed", rx_cnt - r0, 1);
    chk("R11 tx completed", tx_cnt - t0, 1);
    chk("R11 rx first", int'(rx_cyc < tx_cyc), 1);
    chk("R11 tx len", int'(sent_log[3]), 16);
    chk("R4 msg len", int'(mem[widx(RXB, 3, 6)]), 44);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_rx_basic();
    t_rx_exact();
    t_rx_index();
    t_rx_drop();
    t_rx_bound();
    t_tx_multi();
    t_tx_bound();
    t_stop();
    t_both();
    summary();
  end
endmodule